// File: doc/BRIEF.md
# Clock Output Selector

This block drives a single external clock-output pin from one of several on-chip clocks. Software writes a 5-bit control word that holds an enable bit and a 4-bit source code. While the output is starting, running or shutting down, the block holds the oscillator behind the chosen source switched on. It opens and closes a glitch-free gate in the domain of the chosen clock. Two read-only flags report progress: busy and ready.

A start proceeds in order. First the oscillator is requested. When it reports stable, the gate opens. The ready flag then rises once the open state has been synchronized back to the register clock. A stop waits for the gate to close on a low phase of the selected clock and for that closure to cross back, and only then drops both flags together. With a very slow source this takes many register cycles. If the external oscillator fails while it is the selected source, the select code is forced to the divided internal RC clock.

Top module: `clkout_sel`

## Requirements
- R1: After reset, the stored enable bit and select code are 0, busy and ready are 0, all three oscillator requests are 0 and clk_out is low.
- R2: A register write takes bit 0 as the enable bit and bits 4:1 as the select code. When busy is 0, the stored enable bit is 1 and the code is not 0011, busy is 1 on the next cycle.
- R3: While busy is 1, a write updates the enable bit but leaves the stored select code unchanged.
- R4: Each code needs one oscillator. Codes 0000 and 1011 use the internal RC oscillator (rc_req). Code 0001 uses the low-speed RC (ls_req), and code 0010 uses the external oscillator (ext_req). All other codes need none. That request is 1 whenever busy is 1, and all requests are 0 once busy is 0.
- R5: While the requested oscillator's ready input is 0, ready stays 0 and clk_out stays low.
- R6: Once ready is 1, clk_out follows the selected source. The mapping is: 0000 divided internal RC, 0001 low-speed RC, 0010 external, 0100 CPU clock, 0101 to 1010 CPU clock divided by 2, 4, 8, 16, 32 and 64 (src_cpu[1] to src_cpu[6]), 1011 undivided internal RC, 1100 master clock, and 1101 to 1111 CPU clock.
- R7: After the enable bit is cleared, busy and ready both stay 1 until the gate has closed and the closure has been synchronized back. They then fall in the same cycle, and clk_out is low from then on.
- R8: If ext_fail is 1 in a cycle in which the stored code is 0010, the stored code is 0000 on the next cycle, whether busy is 1 or 0.
- R9: Code 0011 selects no source. With that code and the enable bit set, busy and ready stay 0, no oscillator is requested and clk_out stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 5 | Control word: bit 0 enable, bits 4:1 select code |
| reg_en | output | 1 | Stored enable bit |
| reg_sel | output | 4 | Stored select code |
| busy | output | 1 | Output start, run or shutdown in progress |
| ready | output | 1 | Selected clock is being driven to the pin |
| src_rcdiv | input | 1 | Divided internal RC clock |
| src_lsrc | input | 1 | Low-speed RC clock |
| src_ext | input | 1 | External oscillator clock |
| src_rc | input | 1 | Undivided internal RC clock |
| src_mst | input | 1 | Master clock |
| src_cpu | input | 7 | CPU clock (bit 0) and its divisions by 2 to 64 (bits 1 to 6) |
| rc_rdy | input | 1 | Internal RC oscillator stable |
| ls_rdy | input | 1 | Low-speed RC oscillator stable |
| ext_rdy | input | 1 | External oscillator stable |
| ext_fail | input | 1 | External oscillator failure pulse |
| rc_req | output | 1 | Request to run the internal RC oscillator |
| ls_req | output | 1 | Request to run the low-speed RC oscillator |
| ext_req | output | 1 | Request to run the external oscillator |
| clk_out | output | 1 | Gated clock for the output pin |

## Verification
The assertions assume that every source clock toggles while reset is held and keeps running while it is selected. Under that assumption, the source-domain flops leave reset cleanly and the gate closure eventually crosses back. They also assume ext_fail is only raised while the external clock is selected or idle. The bench holds reset for longer than several periods of the slowest source and runs every source clock without pause. It changes the oscillator ready inputs and ext_fail only on register-clock falling edges. It samples clk_out half a nanosecond after those edges, a point where no source clock toggles.

// File: rtl/clkout_pkg.sv
`timescale 1ns/100ps
// Package: shared codes, state type and source-to-oscillator decode for the
// clock output selector. Assumes the 4-bit select encoding is fixed.
package clkout_pkg;
    localparam int SEL_W    = 4;
    localparam int WDATA_W  = SEL_W + 1;
    localparam int CPU_TAPS = 7;
    localparam int N_CODES  = 1 << SEL_W;

    localparam logic [SEL_W-1:0] CODE_RCDIV  = 4'd0;
    localparam logic [SEL_W-1:0] CODE_LSRC   = 4'd1;
    localparam logic [SEL_W-1:0] CODE_EXT    = 4'd2;
    localparam logic [SEL_W-1:0] CODE_NONE   = 4'd3;
    localparam int               CODE_CPU0   = 4;
    localparam int               CODE_CPULST = CODE_CPU0 + CPU_TAPS - 1;
    localparam int               CODE_RC     = 11;
    localparam int               CODE_MST    = 12;

    typedef enum logic [1:0] {OSC_NONE, OSC_RC, OSC_LS, OSC_EXT} osc_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WAKE, ST_OPEN, ST_RUN, ST_CLOSE
    } co_state_e;

    // Oscillator that must run for a given select code
    function automatic osc_e osc_of(input logic [SEL_W-1:0] code);
        case (code)
            CODE_RCDIV, 4'd11: osc_of = OSC_RC;
            CODE_LSRC:         osc_of = OSC_LS;
            CODE_EXT:          osc_of = OSC_EXT;
            default:           osc_of = OSC_NONE;
        endcase
    endfunction
endpackage

// File: rtl/clkout_src_mux.sv
`timescale 1ns/100ps
// Source multiplexer: builds one candidate per select code with a generate
// loop and picks the one named by the stored code. Assumes the code only
// changes while the downstream gate is closed, or when the source has failed.
module clkout_src_mux
    import clkout_pkg::*;
(
    input  logic                src_rcdiv,
    input  logic                src_lsrc,
    input  logic                src_ext,
    input  logic                src_rc,
    input  logic                src_mst,
    input  logic [CPU_TAPS-1:0] src_cpu,
    input  logic [SEL_W-1:0]    sel,
    output logic                clk_sel
);
    logic [N_CODES-1:0] cand;

    // One candidate clock per code
    for (genvar i = 0; i < N_CODES; i++) begin : g_cand
        if (i == 0) begin : g_rcdiv
            assign cand[i] = src_rcdiv;
        end else if (i == 1) begin : g_ls
            assign cand[i] = src_lsrc;
        end else if (i == 2) begin : g_ext
            assign cand[i] = src_ext;
        end else if (i == 3) begin : g_none
            assign cand[i] = 1'b0;
        end else if (i >= CODE_CPU0 && i <= CODE_CPULST) begin : g_cpu
            assign cand[i] = src_cpu[i-CODE_CPU0];
        end else if (i == CODE_RC) begin : g_rc
            assign cand[i] = src_rc;
        end else if (i == CODE_MST) begin : g_mst
            assign cand[i] = src_mst;
        end else begin : g_cpu_alias
            assign cand[i] = src_cpu[0];
        end
    end

    assign clk_sel = cand[sel];
endmodule

// File: rtl/clkout_gate.sv
`timescale 1ns/100ps
// Glitch-free gate: the open request is synchronized into the selected clock,
// the gate enable changes only on that clock's falling edge, and the gate
// state is synchronized back to the register clock as an acknowledge.
// Assumes the selected clock runs during reset so its flops clear.
module clkout_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_clk,
    input  logic open_req,
    output logic ack,
    output logic clk_out
);
    logic [SYNC_STAGES-1:0] fwd_q;
    logic [SYNC_STAGES-1:0] back_q;
    logic                   gate_q;

    // Carry the open request into the selected clock domain
    always_ff @(posedge src_clk) begin
        if (!rst_n) fwd_q <= '0;
        else        fwd_q <= {fwd_q[SYNC_STAGES-2:0], open_req};
    end

    // Move the gate enable only while the selected clock is low
    always_ff @(negedge src_clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= fwd_q[SYNC_STAGES-1];
    end

    // Return the gate state to the register clock
    always_ff @(posedge clk) begin
        if (!rst_n) back_q <= '0;
        else        back_q <= {back_q[SYNC_STAGES-2:0], gate_q};
    end

    assign ack     = back_q[SYNC_STAGES-1];
    assign clk_out = src_clk & gate_q;
endmodule

// File: rtl/clkout_ctrl.sv
`timescale 1ns/100ps
// Control: holds the enable bit and select code, locks the code while busy,
// forces the external code to the divided RC on failure, and sequences
// oscillator request, gate open and gate close. Assumes ack comes from a
// gate that was closed when the request was last low.
module clkout_ctrl
    import clkout_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [WDATA_W-1:0] reg_wdata,
    input  logic               rc_rdy,
    input  logic               ls_rdy,
    input  logic               ext_rdy,
    input  logic               ext_fail,
    input  logic               ack,
    output logic               en,
    output logic [SEL_W-1:0]   sel,
    output logic               busy,
    output logic               ready,
    output logic               open_req,
    output logic               rc_req,
    output logic               ls_req,
    output logic               ext_req
);
    co_state_e        state_q, state_d;
    logic [SEL_W-1:0] sel_d;
    logic             en_d;
    logic             rdy_q;
    logic             osc_ok;
    osc_e             need;

    assign need = osc_of(sel);
    assign busy = (state_q != ST_IDLE);

    // Ready state of the oscillator behind the current code
    always_comb begin
        case (need)
            OSC_RC:  osc_ok = rc_rdy;
            OSC_LS:  osc_ok = ls_rdy;
            OSC_EXT: osc_ok = ext_rdy;
            default: osc_ok = 1'b1;
        endcase
    end

    // Next register contents: write, lock while busy, failure fallback
    always_comb begin
        en_d  = reg_wr ? reg_wdata[0] : en;
        sel_d = (reg_wr && !busy) ? reg_wdata[WDATA_W-1:1] : sel;
        if (ext_fail && sel_d == CODE_EXT) sel_d = CODE_RCDIV;
    end

    // Start, run and shutdown sequence
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (en && sel != CODE_NONE) state_d = ST_WAKE;
            ST_WAKE:  if (!en) state_d = ST_IDLE;
                      else if (osc_ok) state_d = ST_OPEN;
            ST_OPEN:  if (ack) state_d = en ? ST_RUN : ST_CLOSE;
            ST_RUN:   if (!en) state_d = ST_CLOSE;
            ST_CLOSE: if (!ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Register update for fields, state and the ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            sel     <= '0;
            state_q <= ST_IDLE;
            rdy_q   <= 1'b0;
        end else begin
            en      <= en_d;
            sel     <= sel_d;
            state_q <= state_d;
            if (state_d == ST_RUN)  rdy_q <= 1'b1;
            if (state_d == ST_IDLE) rdy_q <= 1'b0;
        end
    end

    assign ready    = rdy_q;
    assign open_req = (state_q == ST_OPEN) || (state_q == ST_RUN);
    assign rc_req   = busy && (need == OSC_RC);
    assign ls_req   = busy && (need == OSC_LS);
    assign ext_req  = busy && (need == OSC_EXT);
endmodule

// File: rtl/clkout_sel.sv
`timescale 1ns/100ps
// Top: clock output selector. Connects control, source multiplexer and
// glitch-free gate. Assumes source clocks run while reset is held.
module clkout_sel
    import clkout_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [WDATA_W-1:0]  reg_wdata,
    output logic                reg_en,
    output logic [SEL_W-1:0]    reg_sel,
    output logic                busy,
    output logic                ready,
    input  logic                src_rcdiv,
    input  logic                src_lsrc,
    input  logic                src_ext,
    input  logic                src_rc,
    input  logic                src_mst,
    input  logic [CPU_TAPS-1:0] src_cpu,
    input  logic                rc_rdy,
    input  logic                ls_rdy,
    input  logic                ext_rdy,
    input  logic                ext_fail,
    output logic                rc_req,
    output logic                ls_req,
    output logic                ext_req,
    output logic                clk_out
);
    logic clk_sel;
    logic open_req;
    logic ack;

    clkout_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .rc_rdy(rc_rdy), .ls_rdy(ls_rdy), .ext_rdy(ext_rdy),
        .ext_fail(ext_fail), .ack(ack), .en(reg_en), .sel(reg_sel),
        .busy(busy), .ready(ready), .open_req(open_req),
        .rc_req(rc_req), .ls_req(ls_req), .ext_req(ext_req)
    );

    clkout_src_mux u_mux (
        .src_rcdiv(src_rcdiv), .src_lsrc(src_lsrc), .src_ext(src_ext),
        .src_rc(src_rc), .src_mst(src_mst), .src_cpu(src_cpu),
        .sel(reg_sel), .clk_sel(clk_sel)
    );

    clkout_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk(clk), .rst_n(rst_n), .src_clk(clk_sel), .open_req(open_req),
        .ack(ack), .clk_out(clk_out)
    );
endmodule

// File: rtl/clkout_sel_chk.sv
`timescale 1ns/100ps
// Checker for the clock output selector, bound to the top module.
// Observes ports only, sampled on the register clock.
module clkout_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_en,
    input logic [3:0] reg_sel,
    input logic       busy,
    input logic       ready,
    input logic       ext_fail,
    input logic       ext_req,
    input logic       clk_out
);
    a_r2_busy_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_en && reg_sel != 4'd3) |=> busy);

    a_r3_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ext_fail) |=> $stable(reg_sel));

    a_r4_ext_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_sel == 4'd2) |-> ext_req);

    a_r6_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> busy);

    a_r7_flags_fall_together: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $fell(busy));

    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> !clk_out);

    a_r8_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_fail && reg_sel == 4'd2) |=> (reg_sel == 4'd0));

    a_r9_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_sel == 4'd3) |=> !busy);
endmodule

bind clkout_sel clkout_sel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_sel(reg_sel),
    .busy(busy), .ready(ready), .ext_fail(ext_fail), .ext_req(ext_req),
    .clk_out(clk_out)
);

// File: tb/test_clkout_sel.sv
`timescale 1ns/100ps
module test_clkout_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_wdata = '0;
    logic       reg_en, busy, ready, rc_req, ls_req, ext_req, clk_out;
    logic [3:0] reg_sel;
    logic       src_rcdiv = 1'b0, src_lsrc = 1'b0, src_ext = 1'b0;
    logic       src_rc = 1'b0, src_mst = 1'b0, cpu = 1'b0;
    logic [5:0] cpu_cnt = '0;
    logic [6:0] src_cpu;
    logic       rc_rdy = 1'b1, ls_rdy = 1'b1, ext_rdy = 1'b1, ext_fail = 1'b0;
    int         checks = 0;
    int         failures = 0;

    always #2  clk = ~clk;
    always #12 src_rcdiv = ~src_rcdiv;
    always #80 src_lsrc = ~src_lsrc;
    always #7  src_ext = ~src_ext;
    always #3  src_rc = ~src_rc;
    always #5  src_mst = ~src_mst;
    always #10 cpu = ~cpu;
    always @(posedge cpu) cpu_cnt <= cpu_cnt + 6'd1;
    assign src_cpu = {cpu_cnt, cpu};

    clkout_sel i_clkout_sel (.*);

    function automatic logic exp_src(input int code);
        case (code)
            0: exp_src = src_rcdiv;
            1: exp_src = src_lsrc;
            2: exp_src = src_ext;
            3: exp_src = 1'b0;
            11: exp_src = src_rc;
            12: exp_src = src_mst;
            default: exp_src = (code >= 4 && code <= 10) ? src_cpu[code-4] : src_cpu[0];
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic en, input logic [3:0] sel);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = {sel, en};
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_flag(input bit want_ready, input logic level);
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if ((want_ready ? ready : busy) == level) return;
        end
    endtask

    task automatic cmp_out(input int code, input int n, input string req);
        int bad = 0;
        logic last = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #0.5;
            if (clk_out !== exp_src(code)) begin
                bad++;
                last = clk_out;
            end
        end
        check(bad == 0, req, last, exp_src(code));
    endtask

    task automatic reqs_for(input int code, input string req);
        logic [2:0] e;
        e = (code == 0 || code == 11) ? 3'b100 : (code == 1) ? 3'b010 :
            (code == 2) ? 3'b001 : 3'b000;
        check({rc_req, ls_req, ext_req} == e, req, {rc_req, ls_req, ext_req}, e);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (120) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({reg_en, reg_sel, busy, ready} == 0, "R1 fields", {reg_en, reg_sel, busy, ready}, 0);
        check({rc_req, ls_req, ext_req} == 0, "R1 requests", {rc_req, ls_req, ext_req}, 0);
        cmp_out(3, 20, "R1 clk_out low");

        // R6 sweep over every usable code, with R2, R4, R7 on each
        for (int code = 0; code < 16; code++) begin
            if (code == 3) continue;
            wr(1'b1, code[3:0]);
            @(negedge clk);
            check(busy == 1'b1, "R2 busy", busy, 1);
            reqs_for(code, "R4 request while busy");
            wait_flag(1'b1, 1'b1);
            check(ready == 1'b1, "R6 ready", ready, 1);
            cmp_out(code, 40, "R6 clk_out follows source");
            wr(1'b0, code[3:0]);
            check(busy && ready, "R7 flags held", {busy, ready}, 3);
            wait_flag(1'b0, 1'b0);
            check(ready == 1'b0, "R7 ready drops with busy", ready, 0);
            reqs_for(3, "R4 requests released");
            cmp_out(3, 20, "R7 clk_out low after close");
        end

        // R5 oscillator not ready: hold off the gate
        ls_rdy = 1'b0;
        wr(1'b1, 4'd1);
        repeat (100) @(negedge clk);
        check(busy && !ready && ls_req, "R5 waiting", {busy, ready, ls_req}, 5);
        cmp_out(3, 20, "R5 clk_out low while waiting");
        ls_rdy = 1'b1;
        wait_flag(1'b1, 1'b1);
        check(ready == 1'b1, "R5 ready after osc", ready, 1);

        // R3 lock while busy, R7 slow shutdown hold
        wr(1'b1, 4'd12);
        check(reg_sel == 4'd1, "R3 select locked", reg_sel, 1);
        wr(1'b0, 4'd12);
        check(reg_en == 1'b0 && reg_sel == 4'd1, "R3 enable writable", {reg_en, reg_sel}, 1);
        repeat (20) @(negedge clk);
        check(busy && ready, "R7 hold during slow close", {busy, ready}, 3);
        wait_flag(1'b0, 1'b0);
        check(ready == 1'b0, "R7 close complete", ready, 0);

        // R8 failure while running on the external clock
        wr(1'b1, 4'd2);
        wait_flag(1'b1, 1'b1);
        @(negedge clk);
        ext_fail = 1'b1;
        @(negedge clk);
        ext_fail = 1'b0;
        check(reg_sel == 4'd0, "R8 fallback busy", reg_sel, 0);
        reqs_for(0, "R8 request moves to RC");
        repeat (30) @(negedge clk);
        cmp_out(0, 40, "R8 clk_out from divided RC");
        wr(1'b0, 4'd0);
        wait_flag(1'b0, 1'b0);

        // R8 failure while idle
        wr(1'b0, 4'd2);
        ext_fail = 1'b1;
        @(negedge clk);
        ext_fail = 1'b0;
        check(reg_sel == 4'd0, "R8 fallback idle", reg_sel, 0);

        // R9 reserved code
        wr(1'b1, 4'd3);
        repeat (30) @(negedge clk);
        check(!busy && !ready, "R9 no start", {busy, ready}, 0);
        reqs_for(3, "R9 no request");
        cmp_out(3, 20, "R9 clk_out low");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule